// File: doc/BRIEF.md
# Genetic Offspring Generator

This unit produces new chromosomes for a hardware genetic search. A chromosome is a vector of `NUM_GENES` genes of `GENE_W` bits. The population lives in an external single-port-style memory whose words hold a chromosome and its score. For each offspring the unit draws two distinct parent indices at random, reads both parents, and builds a child locus by locus: each locus first picks its gene from one parent or the other by a coin flip, then may be overwritten by a random gene.

Each finished child is compared against the offspring already produced since the current search cycle began. A repeated child is replaced by a fully random chromosome, up to a bounded number of attempts; a child that is still a repeat is dropped. A unique child is presented on the output until an external evaluator returns its score. If that score beats the weaker of the two parents, the child overwrites that parent in memory and the stagnation count clears; otherwise the count grows. When the count reaches its limit the unit pulses a cycle-complete flag and goes idle until started again.

All random values come from one internal 16-bit shift-register generator that advances exactly once per value consumed, so the whole offspring stream is a fixed function of the seed, the memory contents and the returned scores.

Top module: `ga_offspring_unit`

## Requirements
- R1: While `rst_n` is low and afterwards until `start` is seen, `rd_en`, `wr_en`, `off_valid` and `cycle_done` are all 0.
- R2: Random values come from a 16-bit register reset to `SEED`; each consumed value is the current register, after which it becomes `{s[14:0], s[15]^s[13]^s[12]^s[10]}`. Values are consumed in this order per offspring: first parent index, second parent index (repeated as needed), then for loci 0 upward a crossover value, a mutation value and, only if mutating, a gene value; then one value per locus (0 upward) for each duplicate replacement. The register is not reloaded between search cycles.
- R3: A parent index is `(v * POP_SIZE) >> 16` for a value `v`; the second index is redrawn while it equals the first, so the two parents always differ.
- R4: Memory words are `{chromosome, score}` with the score in bits `SCORE_W-1:0` and gene k of the chromosome at bits `k*GENE_W +: GENE_W` above it; read data is expected one cycle after `rd_en`, first parent read before the second.
- R5: At each locus the child takes the second parent's gene when the crossover value is below `PC_Q16` (default 32768, one half in 1/65536 units), else the first parent's gene.
- R6: At each locus, when the mutation value is below `PM_Q16` (default 1966, about 0.03), the gene becomes the low `GENE_W` bits of the next value.
- R7: A child equal to any of the last `HIST_DEPTH` offspring presented since `start` is replaced by a random chromosome (low `GENE_W` bits of one value per locus) and checked again; `off_valid` never shows such a repeat.
- R8: At most `MAX_RETRY` replacements are made per child; if the last one is still a repeat the child is dropped without being presented and counts as a non-improvement.
- R9: A presented child stays on `off_chrom` with `off_valid` high until `score_valid`; if `score` is strictly greater than the lower parent score (ties select the first parent), `{child, score}` is written to that parent's index with `wr_en` high in the next cycle, otherwise no write occurs.
- R10: The stagnation count clears on an improving child and increments on a non-improving or dropped one; when it reaches `STAG_LIMIT` (default 25) `cycle_done` is high for exactly one cycle and the unit goes idle.
- R11: `start` is accepted only when idle; it clears the offspring history and the stagnation count, and a `start` during a search cycle has no effect on the offspring stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search cycle when idle |
| rd_en | output | 1 | Population memory read request |
| rd_addr | output | IDX_W | Read index |
| rd_data | input | CHROM_W+SCORE_W | Read word, valid one cycle after `rd_en` |
| wr_en | output | 1 | Population memory write strobe |
| wr_addr | output | IDX_W | Index of the replaced parent |
| wr_data | output | CHROM_W+SCORE_W | Child chromosome and its score |
| off_valid | output | 1 | A unique child awaits its score |
| off_chrom | output | CHROM_W | The child chromosome |
| score_valid | input | 1 | Score for the presented child is on `score` |
| score | input | SCORE_W | Child score |
| cycle_done | output | 1 | One-cycle pulse when the stagnation limit is reached |

## Verification
The bench runs three search cycles over a small chromosome space of eight possible values, so that repeats are common. The first cycle starts from a population of identical chromosomes, which makes crossover alone reproduce the parent and separates correct duplicate replacement and dropping from plain crossover and mutation; later cycles start from the population left by earlier writes and check that the generator state carries over. Returned scores are, per cycle, two clear winners, one exact tie with the weaker parent and then losers, which tells strict comparison and the tie rule apart from a plain replace-always or replace-never choice. A stray `start` in the middle of a cycle shows whether it disturbs the stream.

// File: rtl/ga_pkg.sv
package ga_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SEL_A,
    S_SEL_B,
    S_RD_A,
    S_RD_B,
    S_CAP_B,
    S_XO,
    S_MUT,
    S_MUTV,
    S_DUP,
    S_RAND,
    S_EMIT
  } ga_state_e;

  function automatic logic [15:0] prng_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/ga_prng.sv
module ga_prng #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [15:0] value
);
  import ga_pkg::*;

  logic [15:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (adv) st_d = prng_step(st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign value = st_q;

  // R2: a maximal-length register seeded non-zero never reaches zero
  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 16'h0000);

endmodule

// File: rtl/ga_dup_hist.sv
module ga_dup_hist #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic [W-1:0] probe,
  output logic         hit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [DEPTH-1:0] match;

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (clr) begin
      vld_d = '0;
      ptr_d = '0;
    end else if (push) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  ent_q[gi] <= '0;
        else if (push && !clr && ptr_q == PTR_W'(gi)) ent_q[gi] <= push_data;
      end
      assign match[gi] = vld_q[gi] && (ent_q[gi] == probe);
    end
  endgenerate

  assign hit = |match;

  // R7: a push always lands in a slot and marks it valid
  a_r7_push_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |=> (vld_q != '0));

endmodule

// File: rtl/ga_stag_ctr.sv
module ga_stag_ctr #(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                             cnt_d = '0;
    else if (inc && cnt_q < CNT_W'(LIMIT)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(LIMIT - 1));

  // R10: the count never runs past the limit
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LIMIT));

endmodule

// File: rtl/ga_offspring_unit.sv
module ga_offspring_unit #(
  parameter int          POP_SIZE   = 500,
  parameter int          NUM_GENES  = 8,
  parameter int          GENE_W     = 4,
  parameter int          SCORE_W    = 8,
  parameter int          PC_Q16     = 32768,
  parameter int          PM_Q16     = 1966,
  parameter int          STAG_LIMIT = 25,
  parameter int          HIST_DEPTH = 16,
  parameter int          MAX_RETRY  = 4,
  parameter logic [15:0] SEED       = 16'hACE1,
  localparam int CHROM_W = NUM_GENES * GENE_W,
  localparam int WORD_W  = CHROM_W + SCORE_W,
  localparam int IDX_W   = (POP_SIZE > 1) ? $clog2(POP_SIZE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               rd_en,
  output logic [IDX_W-1:0]   rd_addr,
  input  logic [WORD_W-1:0]  rd_data,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic               off_valid,
  output logic [CHROM_W-1:0] off_chrom,
  input  logic               score_valid,
  input  logic [SCORE_W-1:0] score,
  output logic               cycle_done
);
  import ga_pkg::*;

  localparam int LOC_W   = (NUM_GENES > 1) ? $clog2(NUM_GENES) : 1;
  localparam int RETRY_W = $clog2(MAX_RETRY + 2);

  ga_state_e           state_q, state_d;
  logic [IDX_W-1:0]    idx_a_q, idx_a_d, idx_b_q, idx_b_d;
  logic [WORD_W-1:0]   par_a_q, par_a_d, par_b_q, par_b_d;
  logic [CHROM_W-1:0]  child_q, child_d;
  logic [LOC_W-1:0]    loc_q, loc_d;
  logic [RETRY_W-1:0]  retry_q, retry_d;
  logic                wr_en_q, wr_en_d;
  logic [IDX_W-1:0]    wr_addr_q, wr_addr_d;
  logic [WORD_W-1:0]   wr_data_q, wr_data_d;
  logic                done_q, done_d;

  logic                adv;
  logic [15:0]         draw;
  logic [IDX_W-1:0]    draw_idx;
  logic                xo_take_b, mut_hit;
  logic                loc_last;
  logic                dup_hit, hist_push, hist_clr;
  logic                stag_clr, stag_inc, stag_last;
  logic                worst_is_b;
  logic [IDX_W-1:0]    worst_idx;
  logic [SCORE_W-1:0]  worst_score;

  // ---------------------------------------------------------------
  // Sub-blocks
  // ---------------------------------------------------------------
  ga_prng #(.SEED(SEED)) u_prng (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .value (draw)
  );

  ga_dup_hist #(.W(CHROM_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (hist_clr),
    .push      (hist_push),
    .push_data (child_q),
    .probe     (child_q),
    .hit       (dup_hit)
  );

  ga_stag_ctr #(.LIMIT(STAG_LIMIT)) u_stag (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stag_clr),
    .inc   (stag_inc),
    .last  (stag_last)
  );

  // ---------------------------------------------------------------
  // Derived random decisions
  // ---------------------------------------------------------------
  assign draw_idx  = IDX_W'(({16'h0000, draw} * 32'(POP_SIZE)) >> 16);
  assign xo_take_b = ({1'b0, draw} < 17'(PC_Q16));
  assign mut_hit   = ({1'b0, draw} < 17'(PM_Q16));
  assign loc_last  = (loc_q == LOC_W'(NUM_GENES - 1));

  // weaker parent; a tie selects the first parent
  assign worst_is_b  = (par_b_q[SCORE_W-1:0] < par_a_q[SCORE_W-1:0]);
  assign worst_idx   = worst_is_b ? idx_b_q : idx_a_q;
  assign worst_score = worst_is_b ? par_b_q[SCORE_W-1:0] : par_a_q[SCORE_W-1:0];

  // ---------------------------------------------------------------
  // Next-state logic
  // ---------------------------------------------------------------
  always_comb begin
    state_d   = state_q;
    idx_a_d   = idx_a_q;
    idx_b_d   = idx_b_q;
    par_a_d   = par_a_q;
    par_b_d   = par_b_q;
    child_d   = child_q;
    loc_d     = loc_q;
    retry_d   = retry_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    done_d    = 1'b0;
    adv       = 1'b0;
    rd_en     = 1'b0;
    rd_addr   = idx_a_q;
    hist_push = 1'b0;
    hist_clr  = 1'b0;
    stag_clr  = 1'b0;
    stag_inc  = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (start) begin
          hist_clr = 1'b1;
          stag_clr = 1'b1;
          state_d  = S_SEL_A;
        end
      end

      S_SEL_A: begin
        adv     = 1'b1;
        idx_a_d = draw_idx;
        state_d = S_SEL_B;
      end

      S_SEL_B: begin
        adv = 1'b1;
        if (draw_idx != idx_a_q) begin
          idx_b_d = draw_idx;
          state_d = S_RD_A;
        end
      end

      S_RD_A: begin
        rd_en   = 1'b1;
        rd_addr = idx_a_q;
        state_d = S_RD_B;
      end

      S_RD_B: begin
        rd_en   = 1'b1;
        rd_addr = idx_b_q;
        par_a_d = rd_data;
        state_d = S_CAP_B;
      end

      S_CAP_B: begin
        par_b_d = rd_data;
        loc_d   = '0;
        state_d = S_XO;
      end

      S_XO: begin
        adv = 1'b1;
        child_d[loc_q*GENE_W +: GENE_W] = xo_take_b
          ? par_b_q[SCORE_W + loc_q*GENE_W +: GENE_W]
          : par_a_q[SCORE_W + loc_q*GENE_W +: GENE_W];
        state_d = S_MUT;
      end

      S_MUT: begin
        adv = 1'b1;
        if (mut_hit) begin
          state_d = S_MUTV;
        end else if (loc_last) begin
          retry_d = '0;
          state_d = S_DUP;
        end else begin
          loc_d   = loc_q + 1'b1;
          state_d = S_XO;
        end
      end

      S_MUTV: begin
        adv = 1'b1;
        child_d[loc_q*GENE_W +: GENE_W] = draw[GENE_W-1:0];
        if (loc_last) begin
          retry_d = '0;
          state_d = S_DUP;
        end else begin
          loc_d   = loc_q + 1'b1;
          state_d = S_XO;
        end
      end

      S_DUP: begin
        if (!dup_hit) begin
          state_d = S_EMIT;
        end else if (retry_q < RETRY_W'(MAX_RETRY)) begin
          retry_d = retry_q + 1'b1;
          loc_d   = '0;
          state_d = S_RAND;
        end else begin
          stag_inc = 1'b1;
          if (stag_last) begin
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            state_d = S_SEL_A;
          end
        end
      end

      S_RAND: begin
        adv = 1'b1;
        child_d[loc_q*GENE_W +: GENE_W] = draw[GENE_W-1:0];
        if (loc_last) begin
          state_d = S_DUP;
        end else begin
          loc_d = loc_q + 1'b1;
        end
      end

      S_EMIT: begin
        if (score_valid) begin
          hist_push = 1'b1;
          if (score > worst_score) begin
            wr_en_d   = 1'b1;
            wr_addr_d = worst_idx;
            wr_data_d = {child_q, score};
            stag_clr  = 1'b1;
            state_d   = S_SEL_A;
          end else begin
            stag_inc = 1'b1;
            if (stag_last) begin
              done_d  = 1'b1;
              state_d = S_IDLE;
            end else begin
              state_d = S_SEL_A;
            end
          end
        end
      end

      default: state_d = S_IDLE;
    endcase
  end

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      idx_a_q   <= '0;
      idx_b_q   <= '0;
      par_a_q   <= '0;
      par_b_q   <= '0;
      child_q   <= '0;
      loc_q     <= '0;
      retry_q   <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      idx_a_q   <= idx_a_d;
      idx_b_q   <= idx_b_d;
      par_a_q   <= par_a_d;
      par_b_q   <= par_b_d;
      child_q   <= child_d;
      loc_q     <= loc_d;
      retry_q   <= retry_d;
      wr_en_q   <= wr_en_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
      done_q    <= done_d;
    end
  end

  assign wr_en      = wr_en_q;
  assign wr_addr    = wr_addr_q;
  assign wr_data    = wr_data_q;
  assign cycle_done = done_q;
  assign off_valid  = (state_q == S_EMIT);
  assign off_chrom  = child_q;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  // R3: the two parent reads of one offspring never use the same index
  a_r3_distinct_parents: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr != $past(rd_addr)));

  // R7: a presented child never matches the offspring history
  a_r7_emit_unique: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid |-> !dup_hit);

  // R8: replacement attempts stay within the bound
  a_r8_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q <= RETRY_W'(MAX_RETRY));

  // R9: a write only follows an accepted score
  a_r9_write_after_score: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(off_valid && score_valid));

  // R9: the presented child holds until its score arrives
  a_r9_hold_child: assert property (@(posedge clk) disable iff (!rst_n)
    (off_valid && !score_valid) |=> (off_valid && $stable(off_chrom)));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);

endmodule

// File: tb/sim_ga_offspring_unit.sv
`timescale 1ns/1ps
module sim_ga_offspring_unit;

  localparam int POP   = 16;
  localparam int NG    = 3;
  localparam int GW    = 1;
  localparam int SW    = 8;
  localparam int PC    = 32768;
  localparam int PM    = 1966;
  localparam int STAG  = 25;
  localparam int HIST  = 8;
  localparam int RETRY = 2;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam int CW = NG * GW;
  localparam int WW = CW + SW;
  localparam int IW = $clog2(POP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          rd_en;
  logic [IW-1:0] rd_addr;
  logic [WW-1:0] rd_data;
  logic          wr_en;
  logic [IW-1:0] wr_addr;
  logic [WW-1:0] wr_data;
  logic          off_valid;
  logic [CW-1:0] off_chrom;
  logic          score_valid = 1'b0;
  logic [SW-1:0] score = '0;
  logic          cycle_done;

  always #2 clk = ~clk;

  ga_offspring_unit #(
    .POP_SIZE(POP), .NUM_GENES(NG), .GENE_W(GW), .SCORE_W(SW),
    .PC_Q16(PC), .PM_Q16(PM), .STAG_LIMIT(STAG), .HIST_DEPTH(HIST),
    .MAX_RETRY(RETRY), .SEED(SEED)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .off_valid(off_valid), .off_chrom(off_chrom),
    .score_valid(score_valid), .score(score),
    .cycle_done(cycle_done)
  );

  // population memory served to the design
  logic [WW-1:0] ram [POP];
  always @(posedge clk) begin
    if (rd_en) rd_data <= ram[rd_addr];
    if (wr_en) ram[wr_addr] <= wr_data;
  end

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // ------------------------------------------------------------
  // Reference model, built from the requirements
  // ------------------------------------------------------------
  typedef struct {
    logic [CW-1:0] child;
    logic [SW-1:0] sc;
    bit            wr;
    logic [IW-1:0] addr;
    logic [WW-1:0] data;
  } item_t;

  item_t         q[$];
  logic [15:0]   ms;
  logic [WW-1:0] mmem [POP];
  logic [CW-1:0] mh [HIST];
  int            mhv, mhp;

  function automatic logic [15:0] mdraw();
    logic [15:0] v;
    v  = ms;
    ms = {ms[14:0], ms[15] ^ ms[13] ^ ms[12] ^ ms[10]};
    return v;
  endfunction

  function automatic logic [IW-1:0] ridx(input logic [15:0] v);
    return IW'(({16'h0, v} * 32'(POP)) >> 16);
  endfunction

  function automatic bit mhit(input logic [CW-1:0] c);
    for (int i = 0; i < mhv; i++) if (mh[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_cycle();
    int stag, j, r;
    logic [IW-1:0] a, b, wa;
    logic [WW-1:0] pa, pb;
    logic [CW-1:0] c;
    logic [15:0]   d;
    logic [SW-1:0] ws, sc;
    item_t it;
    stag = 0; j = 0; mhv = 0; mhp = 0;
    while (stag < STAG) begin
      a = ridx(mdraw());
      do b = ridx(mdraw()); while (b == a);
      pa = mmem[a]; pb = mmem[b];
      for (int l = 0; l < NG; l++) begin
        d = mdraw();
        c[l*GW +: GW] = (d < PC) ? pb[SW + l*GW +: GW] : pa[SW + l*GW +: GW];
        d = mdraw();
        if (d < PM) begin
          d = mdraw();
          c[l*GW +: GW] = d[GW-1:0];
        end
      end
      r = 0;
      while (mhit(c) && r < RETRY) begin
        r++;
        for (int l = 0; l < NG; l++) begin
          d = mdraw();
          c[l*GW +: GW] = d[GW-1:0];
        end
      end
      if (mhit(c)) begin
        stag++;
        continue;
      end
      wa = (pb[SW-1:0] < pa[SW-1:0]) ? b : a;
      ws = (pb[SW-1:0] < pa[SW-1:0]) ? pb[SW-1:0] : pa[SW-1:0];
      sc = (j < 2) ? 8'd250 : (j == 2) ? ws : 8'd5;
      it.child = c; it.sc = sc; it.wr = (sc > ws);
      it.addr = wa; it.data = {c, sc};
      mh[mhp] = c; mhp = (mhp + 1) % HIST; if (mhv < HIST) mhv++;
      if (sc > ws) begin
        mmem[wa] = {c, sc};
        stag = 0;
      end else stag++;
      j++;
      q.push_back(it);
    end
  endtask

  // ------------------------------------------------------------
  // Monitor: pops expected items as the design presents results
  // ------------------------------------------------------------
  int  dones = 0;
  bit  mon_on = 1'b0;

  task automatic note_done();
    check(q.size() == 0, "R8 R10 offspring left in queue at cycle_done", q.size(), 0);
    dones++;
    @(negedge clk);
    check(cycle_done == 1'b0, "R10 cycle_done one cycle wide", int'(cycle_done), 0);
  endtask

  initial begin
    item_t it;
    wait (mon_on);
    forever begin
      @(negedge clk);
      if (cycle_done) note_done();
      else if (off_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R7 R8 unexpected offspring", int'(off_chrom), -1);
          it.sc = '0; it.wr = 1'b0; it.addr = '0; it.data = '0; it.child = off_chrom;
        end else begin
          it = q.pop_front();
          check(off_chrom == it.child, "R2 R3 R4 R5 R6 R7 offspring value",
                int'(off_chrom), int'(it.child));
        end
        @(negedge clk);
        check(off_valid == 1'b1, "R9 child held until scored", int'(off_valid), 1);
        score_valid = 1'b1;
        score       = it.sc;
        @(negedge clk);
        score_valid = 1'b0;
        check(wr_en == it.wr, "R9 replacement write strobe", int'(wr_en), int'(it.wr));
        if (it.wr) begin
          check(wr_addr == it.addr, "R9 replaced index", int'(wr_addr), int'(it.addr));
          check(wr_data == it.data, "R9 written word", int'(wr_data), int'(it.data));
        end
        if (cycle_done) note_done();
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  // ------------------------------------------------------------
  // Driver
  // ------------------------------------------------------------
  task automatic drive_cycle();
    model_cycle();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < POP; i++) begin
      ram[i]  = {3'b101, SW'(100 + i)};
      mmem[i] = {3'b101, SW'(100 + i)};
    end
    ms = SEED;
    repeat (3) @(negedge clk);
    check({rd_en, wr_en, off_valid, cycle_done} == 4'b0000, "R1 outputs in reset",
          int'({rd_en, wr_en, off_valid, cycle_done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({rd_en, wr_en, off_valid, cycle_done} == 4'b0000, "R1 R11 idle before start",
          int'({rd_en, wr_en, off_valid, cycle_done}), 0);
    mon_on = 1'b1;

    // cycle 1: identical population, repeats are frequent
    drive_cycle();
    wait (dones == 1);

    // cycle 2: stray start mid-cycle must change nothing (R11)
    drive_cycle();
    wait (off_valid);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (dones == 2);

    // cycle 3: generator carries on from its state (R2)
    drive_cycle();
    wait (dones == 3);

    repeat (4) @(negedge clk);
    check(off_valid == 1'b0 && rd_en == 1'b0, "R10 R11 idle after final cycle",
          int'({off_valid, rd_en}), 0);
    for (int i = 0; i < POP; i++)
      check(ram[i] == mmem[i], "R9 population contents", int'(ram[i]), int'(mmem[i]));

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule